// File: doc/BRIEF.md
# SPI Register Access Controller

This block reads or writes one register of an SPI peripheral. Each access is a single 24-bit frame. A user-side request carries a direction flag, a 10-bit register address and a data byte. The controller builds a 16-bit instruction word from the flag and the address. It then drives chip select, the serial clock and the outbound data line itself, and samples the inbound line.

A write sends the instruction word and then the data byte. A read sends the instruction word and then clocks eight more bit periods to collect the peripheral's answer. Chip select stays low from the first bit to the last.

The serial clock idles low. The controller changes outbound data on the rising edge, and both sides sample on the falling edge. The length of each clock half-period is set, in system clock cycles, by a divider input. A finished access raises a one-cycle done pulse. The last byte read is held on the read-data output until another read completes.

Top module: `spi_reg_xact`

## Requirements
- R1: The first 16 bits sent form the instruction word. Bit 15 is the direction (1 = write, 0 = read). Bits 14:12 are the byte-count field and are always 000. Bits 11:10 are 0. Bits 9:0 carry the address. The word is sent most significant bit first.
- R2: On a write, the 8 bits after the instruction word are the write data, most significant bit first.
- R3: On a read, the controller sends zeros after the instruction word. It captures the peripheral's byte from the last 8 falling clock edges, most significant bit first, and presents it on the read-data output.
- R4: The serial clock is low whenever chip select is high. Each access produces exactly 48 clock edges (24 rising, 24 falling), all while chip select is held low. Outbound data changes only on rising edges.
- R5: Each clock high and low phase lasts H system cycles, where H is the divider value, or 1 when the divider is 0. The divider is held stable during an access.
- R6: A request is taken only while the controller is idle. Busy is high from the cycle after acceptance until the done pulse. A request made while busy causes no frame.
- R7: Done is a one-cycle pulse at the end of every access. The read-data output changes only together with done, and only on reads. A write leaves it unchanged.
- R8: After an access, chip select stays high for at least H system cycles before the next one. The outbound data line is low whenever chip select is high.
- R9: After reset, chip select is high, clock and data lines are low, and busy, done and read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Clock half-period in system cycles (0 acts as 1) |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Last byte read, held |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Data to the peripheral |
| spi_miso | input | 1 | Data from the peripheral |

## Verification
The done pulse and a fresh request can fall in the same cycle. This happens when a caller chains accesses back to back. The bench provokes it by raising a request exactly in the done cycle and holding it one more cycle. The request must not start a frame during the done cycle. It must be taken one cycle later. The frame it starts must still follow the minimum chip-select high gap and carry the correct bits. A second collision comes from a foreign request pulsed in the middle of an access. It is judged by the peripheral model, which must see no extra frame and no corrupted bits.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  localparam int INSTR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_RUN, ST_TAIL, ST_GAP, ST_DONE
  } xact_state_t;

  // Instruction word: direction at the top, byte-count field forced to zero,
  // address right-aligned with unused bits zero.
  function automatic logic [INSTR_W-1:0] make_instr(input logic wr,
                                                    input logic [INSTR_W-1:0] addr_ext);
    logic [INSTR_W-1:0] w;
    w        = addr_ext;
    w[15]    = wr;
    w[14:12] = 3'b000;
    return w;
  endfunction

  // Effective half-period length in system cycles.
  function automatic logic [15:0] eff_half(input logic [15:0] div);
    return (div == 16'd0) ? 16'd1 : div;
  endfunction

endpackage

// File: rtl/sclk_timer.sv
module sclk_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  import spi_xact_pkg::*;

  logic [15:0] cnt;
  logic [15:0] lim;

  assign lim  = eff_half(16'(half_div)) - 16'd1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 16'd1;
  end

  // R5: the phase counter never runs past the programmed half-period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= lim));

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_val;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign msb = sh[W-1];

  // R4: a load and a shift are never requested together
  p_load_xor_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clear)  q <= '0;
    else if (sample) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/spi_reg_xact.sv
module spi_reg_xact #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  import spi_xact_pkg::*;

  localparam int FRAME_W = INSTR_W + DATA_W;
  localparam int EDGES   = 2 * FRAME_W;
  localparam int ECW     = $clog2(EDGES + 1);

  xact_state_t state;
  logic [ECW-1:0] edge_cnt;
  logic sclk_q, mosi_q, cs_n_q, rd_q;
  logic [DATA_W-1:0] rdata_q;

  // named internal events
  logic accept, phase_on, tick, rise_ev, fall_ev, last_fall, frame_msb;
  logic [DATA_W-1:0] rx_byte;
  logic [FRAME_W-1:0] frame_word;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign phase_on  = (state == ST_LEAD) || (state == ST_RUN) ||
                     (state == ST_TAIL) || (state == ST_GAP);
  assign rise_ev   = tick && (state == ST_RUN) && !sclk_q;
  assign fall_ev   = tick && (state == ST_RUN) &&  sclk_q;
  assign last_fall = fall_ev && (edge_cnt == ECW'(EDGES - 1));
  assign frame_word = {make_instr(req_write, INSTR_W'(req_addr)),
                       req_write ? req_wdata : {DATA_W{1'b0}}};

  sclk_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(phase_on), .half_div(half_div), .tick(tick));

  frame_shifter #(.W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(frame_word),
    .shift(rise_ev), .msb(frame_msb));

  rx_capture #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(fall_ev),
    .din(spi_miso), .q(rx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      rd_q     <= 1'b0;
      rdata_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_LEAD;
          cs_n_q   <= 1'b0;
          rd_q     <= !req_write;
          edge_cnt <= '0;
        end
        ST_LEAD: if (tick) state <= ST_RUN;
        ST_RUN: if (tick) begin
          sclk_q   <= !sclk_q;
          edge_cnt <= edge_cnt + 1'b1;
          if (rise_ev)   mosi_q <= frame_msb;
          if (last_fall) state  <= ST_TAIL;
        end
        ST_TAIL: if (tick) begin
          state  <= ST_GAP;
          cs_n_q <= 1'b1;
          mosi_q <= 1'b0;
        end
        ST_GAP: if (tick) begin
          state <= ST_DONE;
          if (rd_q) rdata_q <= rx_byte;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign rdata    = rdata_q;
  assign spi_cs_n = cs_n_q;
  assign spi_sclk = sclk_q;
  assign spi_mosi = mosi_q;

  // R4: clock stays low while deselected
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R4: the edge counter never exceeds one frame
  p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (edge_cnt < ECW'(EDGES)) && !spi_cs_n);
  // R8: data line low while deselected
  p_mosi_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi);
  // R6: an accepted request makes the block busy and selects the peripheral
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !spi_cs_n);
  // R6: done only ever occurs inside a busy window
  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: read data changes only together with done
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

endmodule

// File: tb/sim_spi_reg_xact.sv
module sim_spi_reg_xact;
  localparam int ADDR_W = 10, DATA_W = 8, DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [DIV_W-1:0]  half_div = '0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic busy, done, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;
  logic [DATA_W-1:0] rdata;

  spi_reg_xact #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [23:0] q_frame[$];
  logic [7:0]  q_rd[$];
  int          q_half[$];
  logic [7:0]  model_rd = 8'h00;
  int          cur_half = 1;

  // peripheral model: shifts in on falling edges, drives reply on rising edges
  logic [23:0] s_shift;
  logic [7:0]  s_byte = 8'h00;
  int s_rise = 0, s_fall = 0, hi_start = 0, hi_w = 0, t_csrise = -1;

  always @(negedge spi_cs_n) begin
    s_rise = 0; s_fall = 0; s_shift = '0;
    if (t_csrise >= 0) chk("R8 cs high gap", 32'(cyc - t_csrise >= cur_half), 32'd1);
  end
  always @(posedge spi_sclk) begin
    if (s_rise == 0) hi_start = cyc;
    if (s_rise >= 16 && s_rise < 24) spi_miso = s_byte[23 - s_rise];
    s_rise++;
  end
  always @(negedge spi_sclk) begin
    if (s_fall == 0) hi_w = cyc - hi_start;
    s_shift = {s_shift[22:0], spi_mosi};
    s_fall++;
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    t_csrise = cyc;
    if (q_frame.size() == 0) begin
      chk("R6 unexpected frame", 32'd1, 32'd0);
    end else begin
      logic [23:0] ef;
      int eh;
      ef = q_frame.pop_front();
      eh = q_half.pop_front();
      cur_half = eh;
      chk("R1 instruction word", 32'(s_shift[23:8]), 32'(ef[23:8]));
      chk("R2/R3 third byte on mosi", 32'(s_shift[7:0]), 32'(ef[7:0]));
      chk("R4 edge count", 32'(s_rise + s_fall), 32'd48);
      chk("R5 half period", 32'(hi_w), 32'(eh));
    end
  end

  // done monitor
  always @(negedge clk) if (rst_n && done) begin
    if (q_rd.size() == 0) chk("R7 spurious done", 32'd1, 32'd0);
    else chk("R3/R7 rdata at done", 32'(rdata), 32'(q_rd.pop_front()));
    chk("R8 lines idle at done", 32'({spi_cs_n, spi_mosi, spi_sclk}), 32'b100);
  end

  task automatic xact(input logic w, input logic [9:0] a, input logic [7:0] wd,
                      input logic [7:0] sb, input logic [7:0] h,
                      input logic poke, input logic early);
    int eh;
    eh = (h == 0) ? 1 : int'(h);
    if (early) begin
      // request raised in the done cycle: must wait one cycle to be taken
      chk("R6 done cycle before early request", 32'(done), 32'd1);
    end else begin
      @(negedge clk);
      while (busy) @(negedge clk);
    end
    half_div = h; s_byte = sb;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
    q_frame.push_back({w, 3'b000, 2'b00, a, (w ? wd : 8'h00)});
    if (!w) model_rd = sb;
    q_rd.push_back(model_rd);
    q_half.push_back(eh);
    if (early) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset cs_n", 32'(spi_cs_n), 32'd1);
    chk("R9 reset sclk", 32'(spi_sclk), 32'd0);
    chk("R9 reset mosi", 32'(spi_mosi), 32'd0);
    chk("R9 reset busy/done", 32'({busy, done}), 32'd0);
    chk("R9 reset rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;

    xact(1'b1, 10'h3A5, 8'hC3, 8'h00, 8'd2, 1'b0, 1'b0); // R2 write
    xact(1'b0, 10'h012, 8'hEE, 8'h5A, 8'd2, 1'b0, 1'b0); // R3 read
    xact(1'b1, 10'h3FF, 8'hFF, 8'h00, 8'd1, 1'b1, 1'b0); // R6 ignored poke
    xact(1'b0, 10'h000, 8'h00, 8'hA5, 8'd5, 1'b0, 1'b0); // R5 long half
    xact(1'b1, 10'h155, 8'h00, 8'h3C, 8'd3, 1'b0, 1'b0); // R7 write keeps rdata
    xact(1'b0, 10'h2AA, 8'h77, 8'h81, 8'd0, 1'b0, 1'b1); // R5 div 0, early request
    xact(1'b0, 10'h0F0, 8'h00, 8'h00, 8'd3, 1'b1, 1'b1); // R3 zero byte, poke

    @(negedge clk);
    chk("R7 done single cycle", 32'(done), 32'd0);
    chk("R6 idle after done", 32'(busy), 32'd0);
    repeat (10) @(negedge clk);
    chk("R7 rdata held", 32'(rdata), 32'h00);
    chk("R6 no frames left", 32'(q_frame.size()), 32'd0);
    chk("R8 idle lines", 32'({spi_cs_n, spi_mosi, spi_sclk}), 32'b100);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule